// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM command bus. On every rising clock edge it samples chip select, the three strobes (row, column, write), clock enable, the bank-select bits and the address bits. It classifies the cycle as one of ten command kinds and presents that class on a registered output. Alongside the class it keeps, for each bank, whether a row is open and which row that is. This covers explicit single-bank and all-bank precharge and the delayed close that follows a read or write carrying an auto-precharge request.

The block also holds the last accepted mode register op-code. It checks the command stream against the protocol: activating an open bank, accessing an idle bank, loading the mode register while any bank is open, and issuing work during the mode-load recovery window all count as violations. Each violation raises a one-cycle error pulse, and the offending command is discarded. A command sampled at a clock edge shows its class, its error flag and its effect on bank and mode state on the outputs right after that same edge.

Top module: `sdcmd_tracker`

## Requirements
- R1: While rst_n is low, and right after it is released, cmd_o is 0 (inhibit), err_o is 0, every bank_open_o bit is 0, every bank row is 0 and mode_o is 0.
- R2: With cs_n low, the strobes {ras_n,cas_n,we_n} map to cmd_o values as follows: 111→1 (no-op), 011→2 (activate), 101→3 (read), 100→4 (write), 110→5 (burst terminate), 010→6 (precharge), 000→9 (mode load). cmd_o shows the class of the command sampled at the same edge.
- R3: With cs_n high, cmd_o is 0 whatever the other pins are. err_o stays 0 and no bank or mode state changes.
- R4: Strobes 001 with cs_n low give cmd_o 7 (auto refresh) when cke is high and 8 (self refresh) when cke is low.
- R5: An activate to an idle bank sets that bank's bank_open_o bit and stores addr[11:0] in bank_row_o[12*b +: 12], where b is the value of ba.
- R6: An activate to a bank that is already open raises err_o, and that bank's row is left unchanged.
- R7: A precharge with addr[10] low closes only bank ba. A precharge with addr[10] high closes every bank regardless of ba.
- R8: A read or write to an idle bank raises err_o and changes no bank state.
- R9: A read or write to an open bank with addr[10] high keeps the bank open for BURST_LEN-1 further edges and closes it at the BURST_LEN-th edge after the command. A read or write to that bank while this close is pending raises err_o. With addr[10] low the bank stays open.
- R10: A mode load while any bank is open raises err_o and leaves mode_o unchanged.
- R11: A mode load with all banks idle and outside the recovery window stores addr[11:0] in mode_o without error.
- R12: For TMRD-1 edges after an accepted mode load, any command other than no-op or inhibit raises err_o and is discarded. No-op and inhibit in that window raise no error. The edge TMRD after the load accepts commands again.
- R13: err_o is high for exactly the edge of the offending command and is low again after a following no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock, rising edge sampling |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable, selects auto vs self refresh |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column, precharge-all flag or op-code |
| cmd_o | output | 4 | Class of the command sampled at the last edge |
| err_o | output | 1 | One-cycle protocol violation pulse |
| bank_open_o | output | 4 | One bit per bank, high when a row is open |
| bank_row_o | output | 48 | Open row per bank, bank b at bits 12*b+11..12*b |
| mode_o | output | 12 | Last accepted mode register op-code |

## Verification
The decoder is swept over all sixteen strobe and select combinations at both clock-enable levels, with a reset between each one. This separates the inhibit, no-op and two refresh flavours and shows that an idle-bank read or write errors while other commands do not. Bank tracking is exercised by opening all four banks with distinct rows and then closing them with single-bank and all-bank precharges. This distinguishes per-bank selection from broadcast. The auto-precharge countdown is sampled on every edge up to the closing edge, and mode loads are issued inside, at the end of and after the recovery window to locate its exact boundary.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_ACT     = 4'd2,
    CMD_RD      = 4'd3,
    CMD_WR      = 4'd4,
    CMD_BTERM   = 4'd5,
    CMD_PRE     = 4'd6,
    CMD_AREF    = 4'd7,
    CMD_SREF    = 4'd8,
    CMD_MRS     = 4'd9
  } cmd_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_INHIBIT;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BTERM;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
        default: cmd = CMD_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             close_req,
  input  logic             ap_req,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q,
  output logic             ap_busy
);
  localparam int CNT_W = (BURST_LEN < 2) ? 1 : $clog2(BURST_LEN);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_d, row_r;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             row_en;

  always_comb begin
    open_d = open_q;
    row_d  = row_r;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    row_en = 1'b0;
    if (close_req) begin
      open_d = 1'b0;
      pend_d = 1'b0;
    end else if (open_req) begin
      open_d = 1'b1;
      row_d  = row_in;
      row_en = 1'b1;
    end else if (ap_req) begin
      pend_d = 1'b1;
      cnt_d  = CNT_W'(BURST_LEN - 1);
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        open_d = 1'b0;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_r <= '0;
    end else if (row_en) begin
      row_r <= row_d;
    end
  end

  assign is_open = open_q;
  assign row_q   = row_r;
  assign ap_busy = pend_q;
endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NBANKS    = 4,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int TMRD      = 2,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NBANKS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic                    cke,
  input  logic [BA_W-1:0]         ba,
  input  logic [ROW_W-1:0]        addr,
  output logic [3:0]              cmd_o,
  output logic                    err_o,
  output logic [NBANKS-1:0]       bank_open_o,
  output logic [NBANKS*ROW_W-1:0] bank_row_o,
  output logic [ROW_W-1:0]        mode_o
);
  localparam int MRD_W = (TMRD < 2) ? 1 : $clog2(TMRD);

  cmd_e              cmd_now;
  cmd_e              cmd_q;
  logic              err_d, err_q;
  logic [ROW_W-1:0]  mode_q;
  logic              mode_en;
  logic [MRD_W-1:0]  mrd_q, mrd_d;
  logic [NBANKS-1:0] open_v, busy_v;
  logic              is_exec, hit_open, hit_busy;
  logic              bad_act, bad_rw, bad_mrs, bad_mrd, accept;

  sdcmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cke   (cke),
    .cmd   (cmd_now)
  );

  always_comb begin
    is_exec  = (cmd_now != CMD_INHIBIT) && (cmd_now != CMD_NOP);
    hit_open = open_v[ba];
    hit_busy = busy_v[ba];
    bad_act  = (cmd_now == CMD_ACT) && hit_open;
    bad_rw   = ((cmd_now == CMD_RD) || (cmd_now == CMD_WR)) && (!hit_open || hit_busy);
    bad_mrs  = (cmd_now == CMD_MRS) && (|open_v);
    bad_mrd  = (mrd_q != '0) && is_exec;
    err_d    = bad_act | bad_rw | bad_mrs | bad_mrd;
    accept   = !err_d;
    mode_en  = accept && (cmd_now == CMD_MRS);
    if (mode_en) begin
      mrd_d = MRD_W'(TMRD - 1);
    end else if (mrd_q != '0) begin
      mrd_d = mrd_q - 1'b1;
    end else begin
      mrd_d = mrd_q;
    end
  end

  for (genvar gi = 0; gi < NBANKS; gi++) begin : g_bank
    logic sel, open_req, close_req, ap_req;
    always_comb begin
      sel       = (ba == BA_W'(gi));
      open_req  = accept && (cmd_now == CMD_ACT) && sel;
      close_req = accept && (cmd_now == CMD_PRE) && (addr[AP_BIT] || sel);
      ap_req    = accept && ((cmd_now == CMD_RD) || (cmd_now == CMD_WR)) &&
                  addr[AP_BIT] && sel;
    end
    sdcmd_bank #(
      .ROW_W     (ROW_W),
      .BURST_LEN (BURST_LEN)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_req  (open_req),
      .close_req (close_req),
      .ap_req    (ap_req),
      .row_in    (addr),
      .is_open   (open_v[gi]),
      .row_q     (bank_row_o[gi*ROW_W +: ROW_W]),
      .ap_busy   (busy_v[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_INHIBIT;
      err_q <= 1'b0;
      mrd_q <= '0;
    end else begin
      cmd_q <= cmd_now;
      err_q <= err_d;
      mrd_q <= mrd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= addr;
    end
  end

  assign cmd_o       = cmd_q;
  assign err_o       = err_q;
  assign bank_open_o = open_v;
  assign mode_o      = mode_q;
endmodule

// File: rtl/sdcmd_tracker_chk.sv
module sdcmd_tracker_chk
  import sdcmd_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int ROW_W  = 12,
  parameter int AP_BIT = 10,
  parameter int BA_W   = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [BA_W-1:0]         ba,
  input logic [ROW_W-1:0]        addr,
  input logic [3:0]              cmd_o,
  input logic                    err_o,
  input logic [NBANKS-1:0]       bank_open_o,
  input logic [NBANKS*ROW_W-1:0] bank_row_o,
  input logic [ROW_W-1:0]        mode_o
);
  a_r3_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_INHIBIT) |-> (!err_o && $stable(mode_o)));

  a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT && !err_o) |-> bank_open_o[$past(ba)]);

  a_r6_act_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT && err_o) |-> $stable(bank_row_o));

  a_r7_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE && !err_o && $past(addr[AP_BIT])) |-> (bank_open_o == '0));

  a_r10_mrs_err_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS && err_o) |-> $stable(mode_o));

  a_r11_mrs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS && !err_o) |-> ((bank_open_o == '0) && (mode_o == $past(addr))));
endmodule

bind sdcmd_tracker sdcmd_tracker_chk #(
  .NBANKS (NBANKS),
  .ROW_W  (ROW_W),
  .AP_BIT (AP_BIT),
  .BA_W   (BA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ba          (ba),
  .addr        (addr),
  .cmd_o       (cmd_o),
  .err_o       (err_o),
  .bank_open_o (bank_open_o),
  .bank_row_o  (bank_row_o),
  .mode_o      (mode_o)
);

// File: tb/test_sdcmd_tracker.sv
module test_sdcmd_tracker;
  localparam int BL   = 4;
  localparam int TMRD = 2;

  logic        clk, rst_n;
  logic        cs_n, ras_n, cas_n, we_n, cke;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [3:0]  cmd_o;
  logic        err_o;
  logic [3:0]  bank_open_o;
  logic [47:0] bank_row_o;
  logic [11:0] mode_o;

  int checks = 0;
  int errors = 0;

  sdcmd_tracker #(.TMRD(TMRD), .BURST_LEN(BL)) i_sdcmd_tracker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .err_o(err_o), .bank_open_o(bank_open_o), .bank_row_o(bank_row_o),
    .mode_o(mode_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic c, logic r, logic ca, logic w, logic k,
                       logic [1:0] b, logic [11:0] a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic nop();           drive(0, 1, 1, 1, 1, 2'd0, 12'h0); endtask
  task automatic act(logic [1:0] b, logic [11:0] r); drive(0, 0, 1, 1, 1, b, r); endtask
  task automatic rd(logic [1:0] b, logic [11:0] a);  drive(0, 1, 0, 1, 1, b, a); endtask
  task automatic wr(logic [1:0] b, logic [11:0] a);  drive(0, 1, 0, 0, 1, b, a); endtask
  task automatic pre(logic [1:0] b, logic [11:0] a); drive(0, 0, 1, 0, 1, b, a); endtask
  task automatic mrs(logic [11:0] a);                drive(0, 0, 0, 0, 1, 2'd0, a); endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; cke = 1; ba = 0; addr = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_cmd(logic c, logic [2:0] s, logic k);
    if (c) return 4'd0;
    case (s)
      3'b111: return 4'd1;
      3'b011: return 4'd2;
      3'b101: return 4'd3;
      3'b100: return 4'd4;
      3'b110: return 4'd5;
      3'b010: return 4'd6;
      3'b001: return k ? 4'd7 : 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; cke = 1; ba = 0; addr = 0;
    @(negedge clk);
    // R1 reset state while held and after release
    check("R1 cmd", cmd_o, 0);
    check("R1 open", bank_open_o, 0);
    check("R1 rows", bank_row_o, 0);
    check("R1 mode", mode_o, 0);
    check("R1 err", err_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cmd after release", cmd_o, 0);

    // R2 R3 R4 decode sweep, banks idle
    for (int v = 0; v < 32; v++) begin
      logic [3:0] e;
      do_reset();
      drive(v[4], v[2], v[1], v[0], v[3], 2'd1, 12'h000);
      e = exp_cmd(v[4], v[2:0], v[3]);
      check($sformatf("R2 R4 decode %0d", v), cmd_o, e);
      check($sformatf("R8 idle access err %0d", v), err_o, (e == 3 || e == 4));
      check($sformatf("R3 R5 open %0d", v), bank_open_o, (e == 2) ? 4'b0010 : 4'b0000);
    end

    // R3 inhibit with all strobes low changes nothing
    do_reset();
    drive(1, 0, 0, 0, 1, 2'd2, 12'hABC);
    check("R3 inhibit mode", mode_o, 0);
    check("R3 inhibit open", bank_open_o, 0);
    check("R3 inhibit err", err_o, 0);

    // R5 open all banks with distinct rows
    for (int b = 0; b < 4; b++) act(b[1:0], 12'h100 + 12'(b * 17));
    check("R5 open all", bank_open_o, 4'hF);
    for (int b = 0; b < 4; b++)
      check($sformatf("R5 row bank%0d", b), bank_row_o[b*12 +: 12], 12'h100 + 12'(b * 17));

    // R6 activate open bank
    act(2'd2, 12'hFFF);
    check("R6 err", err_o, 1);
    check("R6 row kept", bank_row_o[24 +: 12], 12'h100 + 12'd34);
    nop();
    check("R13 err cleared", err_o, 0);

    // R9 access without auto precharge keeps row open
    rd(2'd0, 12'h005);
    check("R9 read open bank err", err_o, 0);
    for (int j = 0; j < BL + 2; j++) nop();
    check("R9 no ap stays open", bank_open_o[0], 1);

    // R10 mode load with banks open
    mrs(12'h123);
    check("R10 err", err_o, 1);
    check("R10 mode kept", mode_o, 0);

    // R7 single-bank precharge
    pre(2'd1, 12'h000);
    check("R7 single", bank_open_o, 4'b1101);
    pre(2'd1, 12'h000);
    check("R7 idle precharge no err", err_o, 0);
    // R7 precharge all ignores ba
    pre(2'd1, 12'h400);
    check("R7 all", bank_open_o, 4'b0000);

    // R8 access to idle bank
    wr(2'd3, 12'h000);
    check("R8 write idle err", err_o, 1);
    check("R8 stays idle", bank_open_o, 0);

    // R9 auto precharge timing
    act(2'd2, 12'h055);
    wr(2'd2, 12'h400);
    check("R9 ap cmd edge open", bank_open_o[2], 1);
    for (int j = 1; j <= BL; j++) begin
      nop();
      check($sformatf("R9 ap edge %0d", j), bank_open_o[2], (j < BL));
    end
    // R9 access to bank with pending close
    act(2'd1, 12'h066);
    rd(2'd1, 12'h401);
    rd(2'd1, 12'h002);
    check("R9 pending access err", err_o, 1);
    for (int j = 0; j < BL; j++) nop();
    check("R9 pending closes", bank_open_o[1], 0);

    // R11 mode load while idle
    mrs(12'h5A3);
    check("R11 err", err_o, 0);
    check("R11 mode", mode_o, 12'h5A3);
    // R12 activate inside window discarded
    act(2'd0, 12'h001);
    check("R12 window err", err_o, 1);
    check("R12 window discarded", bank_open_o, 0);
    // R12 no-op in window, then first legal edge
    mrs(12'h0C3);
    for (int j = 1; j < TMRD; j++) begin
      nop();
      check("R12 nop in window", err_o, 0);
    end
    act(2'd3, 12'h077);
    check("R12 boundary err", err_o, 0);
    check("R12 boundary open", bank_open_o, 4'b1000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule